// File: doc/BRIEF.md
# Gated Pulse-Burst Generator

This block turns a level request into a short, self-terminating burst. While the request input is low the block is idle and its output is inactive. When the request rises, the output goes active at once and then blinks with a 50% duty cycle, paced by a free-running tick enable. After a fixed number of low gaps, the output settles at its active level and stays there until the request is withdrawn. A later request starts a fresh burst.

Inside there is a small synchronous binary counter that advances on ticks. A low-order bit of the counter shapes the blink. A higher bit marks the end of the burst: once that bit is set, it blocks further counting, so the counter freezes with the blink bit low. Two parameters set the blink bit and how far above it the stop bit sits. Together they fix the blink period and the number of gaps. The request is asynchronous to the system clock and passes through a flop synchroniser before use.

Top module: `burst_gen`

## Requirements
- R1: After reset, and whenever the synchronised request is low, `burst_out` is 0 and `frozen` is 0. A request that is low also clears the internal count.
- R2: The request reaches the logic through a two-stage synchroniser. `burst_out` goes to 1 on the second clock edge after `trig_in` rises, with no extra counting delay.
- R3: During a burst, each active phase and each inactive phase of `burst_out` lasts exactly 2^N_TAP ticks.
- R4: The count advances only on clock edges where `tick` is 1. With `tick` held at 0, `burst_out` stays in its current phase.
- R5: With STOP_OFFSET = 2, a request held long enough gives exactly two inactive gaps. After them, `burst_out` is held at 1 and `frozen` reads 1.
- R6: With STOP_OFFSET = 3, a held request gives exactly four inactive gaps before the freeze. In general the gap count is 2^(STOP_OFFSET-1).
- R7: Once frozen, the block ignores further ticks. `burst_out` stays 1 and `frozen` stays 1 for as long as the request stays high.
- R8: If the request falls during a burst, `burst_out` goes to 0 on the second clock edge after the fall. The current pulse is cut short and not completed.
- R9: A new request after a withdrawn one restarts from a cleared count. The burst then repeats the same phase sequence from its first active phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable that paces the burst |
| trig_in | input | 1 | Asynchronous burst request, active high |
| burst_out | output | 1 | Burst output, active high |
| frozen | output | 1 | High while the count is halted at the stop bit with the request high |

## Verification
The bench builds two copies of the block that share their inputs. Both use N_TAP = 1. One uses STOP_OFFSET = 2 and the other STOP_OFFSET = 3, so a single held request shows the two-gap and four-gap endings side by side. The short 2-tick phase lets a full burst finish in a few dozen cycles. This keeps the following cases within reach of short directed runs: an exact phase-by-phase pattern with a tick on every cycle, stretched gaps with a tick on every third cycle, a stalled tick, and a request withdrawn partway through a pulse.

// File: rtl/burst_pkg.sv
package burst_pkg;

    // Control view of the block: request seen after sync, and whether the
    // counter has reached its stop bit.
    typedef struct packed {
        logic run;
        logic stopped;
    } burst_ctl_t;

    // Counter width needed to hold the stop bit.
    function automatic int unsigned cnt_width(input int unsigned tap,
                                              input int unsigned off);
        return tap + off + 1;
    endfunction

    // Number of inactive gaps produced before the freeze.
    function automatic int unsigned gap_count(input int unsigned off);
        return 32'd1 << (off - 1);
    endfunction

endpackage

// File: rtl/burst_sync.sv
module burst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] stage_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= 1'b0;
                    else     stage_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= 1'b0;
                    else     stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/burst_counter.sv
module burst_counter
    import burst_pkg::*;
#(
    parameter int unsigned N_TAP       = 1,
    parameter int unsigned STOP_OFFSET = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic pulse_tap,
    output logic stop_tap
);
    localparam int unsigned CNT_W    = cnt_width(N_TAP, STOP_OFFSET);
    localparam int unsigned STOP_BIT = N_TAP + STOP_OFFSET;

    logic [CNT_W-1:0] cnt_q;
    logic             advance;

    // The stop bit gates its own count enable: once set, nothing moves.
    assign advance = run & tick & ~cnt_q[STOP_BIT];

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt_q <= '0;
        else if (advance) cnt_q <= cnt_q + CNT_W'(1);
    end

    assign pulse_tap = cnt_q[N_TAP];
    assign stop_tap  = cnt_q[STOP_BIT];

    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0));                                        // R1
    AST_TICK_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !stop_tap && $past(run)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R4
    AST_NO_TICK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> (run ? $stable(cnt_q) : 1'b1));              // R4
    AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (run && stop_tap) |=> (!run || $stable(cnt_q)));                // R7
    AST_FREEZE_PHASE: assert property (@(posedge clk) disable iff (rst)
        stop_tap |-> !pulse_tap);                                       // R5

endmodule

// File: rtl/burst_gen.sv
module burst_gen
    import burst_pkg::*;
#(
    parameter int unsigned N_TAP       = 1,
    parameter int unsigned STOP_OFFSET = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic trig_in,
    output logic burst_out,
    output logic frozen
);
    logic       trig_s;
    logic       pulse_tap;
    logic       stop_tap;
    burst_ctl_t ctl;

    burst_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .d_async (trig_in),
        .q_sync  (trig_s)
    );

    burst_counter #(.N_TAP(N_TAP), .STOP_OFFSET(STOP_OFFSET)) cnt_i (
        .clk       (clk),
        .rst       (rst),
        .run       (ctl.run),
        .tick      (tick),
        .pulse_tap (pulse_tap),
        .stop_tap  (stop_tap)
    );

    assign ctl.run     = trig_s;
    assign ctl.stopped = stop_tap;

    // Active when requested and the blink bit is low.
    assign burst_out = ctl.run & ~pulse_tap;
    assign frozen    = ctl.run & ctl.stopped;

    AST_START_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        $rose(trig_s) |-> burst_out);                                   // R2
    AST_FROZEN_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        frozen |-> burst_out);                                          // R5
    AST_STAY_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (frozen && trig_s) |=> (frozen || !trig_s));                    // R7
    AST_DROP_INACTIVE: assert property (@(posedge clk) disable iff (rst)
        $fell(trig_s) |-> (!burst_out && !frozen));                     // R8

endmodule

// File: tb/burst_gen_tb.sv
`timescale 1ns/1ps
module burst_gen_tb_top;
    localparam int unsigned NT = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic trig = 1'b0;
    logic out_a, frz_a, out_b, frz_b;

    int tick_period = 1;
    bit tick_en = 1'b1;
    int ph = 0;
    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    burst_gen #(.N_TAP(NT), .STOP_OFFSET(2)) dut_i (
        .clk(clk), .rst(rst), .tick(tick), .trig_in(trig),
        .burst_out(out_a), .frozen(frz_a));

    burst_gen #(.N_TAP(NT), .STOP_OFFSET(3)) dut_b_i (
        .clk(clk), .rst(rst), .tick(tick), .trig_in(trig),
        .burst_out(out_b), .frozen(frz_b));

    // Tick generator, driven away from the active edge
    always @(negedge clk) begin
        if (ph >= tick_period - 1) ph = 0;
        else ph = ph + 1;
        tick = tick_en && (ph == 0);
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset out_a", out_a, 0);
        chk("R1 reset frozen_a", frz_a, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 idle out_b", out_b, 0);
        chk("R1 idle frozen_b", frz_b, 0);
    endtask

    // Tick every cycle: exact pattern, gap counts, freeze and hold
    task automatic t_full_burst();
        int falls_a = 0, falls_b = 0, low_hold = 0;
        bit prev_a, prev_b;
        int exp_v, c;
        tick_period = 1;
        @(negedge clk); trig = 1'b1;
        @(negedge clk);
        chk("R2 not yet active", out_a, 0);
        @(negedge clk);
        chk("R2 active at second edge", out_a, 1);
        prev_a = 1'b1; prev_b = 1'b1;
        for (int k = 0; k < 40; k++) begin
            // count c = k at this sample; freeze at 2^(NT+off)
            c = k;
            if (k < 12) begin
                if (c >= (1 << (NT + 2))) exp_v = 1;
                else exp_v = (((c >> NT) & 1) == 0) ? 1 : 0;
                chk("R3 pattern", out_a, exp_v);
            end
            if (prev_a && !out_a) falls_a++;
            if (prev_b && !out_b) falls_b++;
            prev_a = out_a; prev_b = out_b;
            @(negedge clk);
        end
        chk("R5 two gaps", falls_a, 2);
        chk("R6 four gaps", falls_b, 4);
        chk("R5 frozen_a", frz_a, 1);
        chk("R6 frozen_b", frz_b, 1);
        chk("R5 out_a active", out_a, 1);
        chk("R6 out_b active", out_b, 1);
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (!out_a || !out_b || !frz_a || !frz_b) low_hold++;
        end
        chk("R7 held while frozen", low_hold, 0);
        trig = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 out after release", out_a, 0);
        chk("R1 frozen after release", frz_a, 0);
        repeat (4) @(negedge clk);
    endtask

    // Tick every third cycle: gaps stretch to 2^NT * 3 cycles
    task automatic t_slow_tick();
        int low_a = 0, low_b = 0;
        tick_period = 3;
        @(negedge clk); trig = 1'b1;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 90; k++) begin
            if (!out_a) low_a++;
            if (!out_b) low_b++;
            @(negedge clk);
        end
        chk("R4 low cycles offset2", low_a, 2 * (1 << NT) * 3);
        chk("R4 low cycles offset3", low_b, 4 * (1 << NT) * 3);
        chk("R5 frozen slow", frz_a, 1);
        trig = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Tick stalled: output keeps its phase
    task automatic t_no_tick();
        int lows = 0;
        tick_period = 1;
        tick_en = 1'b0;
        @(negedge clk); trig = 1'b1;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            if (!out_a) lows++;
            @(negedge clk);
        end
        chk("R4 no tick keeps phase", lows, 0);
        chk("R4 no tick not frozen", frz_a, 0);
        tick_en = 1'b1;
        trig = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Request withdrawn inside the first active phase, then restart
    task automatic t_abort_restart();
        int highs = 0;
        int exp_v;
        tick_period = 3;
        @(negedge clk); trig = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 active before drop", out_a, 1);
        trig = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R8 cut short a", out_a, 0);
        chk("R8 cut short b", out_b, 0);
        for (int k = 0; k < 20; k++) begin
            if (out_a || out_b) highs++;
            @(negedge clk);
        end
        chk("R8 no completion", highs, 0);
        tick_period = 1;
        @(negedge clk); trig = 1'b1;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            exp_v = (((k >> NT) & 1) == 0) ? 1 : 0;
            chk("R9 restart pattern", out_b, exp_v);
            @(negedge clk);
        end
        trig = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        t_full_burst();
        t_slow_tick();
        t_no_tick();
        t_abort_restart();
        finish_run();
    end

endmodule